// File: doc/BRIEF.md
# UART Receive Channel with Break and Busy Events

This block receives asynchronous serial characters of seven, eight or nine data bits framed by one start bit and one stop bit. It oversamples the line with an internal tick at sixteen times the bit rate and confirms each start bit at its centre. It also samples every data bit and the stop bit at its centre. A finished character goes to a downstream buffer on a one-cycle strobe, but only if that buffer reports itself free. Otherwise the character is thrown away and a busy event is raised.

A line held low for a whole character is a break. The first all-zero character raises a break event once. No matter how long the line stays low, that event is not raised again. When the line has then stayed high for a full bit time, a separate break-end event is raised. A single-cycle pulse from the transmit side also raises an event.

All events are collected in an 8-bit event register that software clears by writing ones. A mask register with the same layout selects which events drive the interrupt line. Bit numbering is MSB-first: field n sits at `reg_rdata[7-n]`.

Top module: `uart_rx_evt`

## Requirements
- R1: One oversampling tick occurs every `baud_div`+1 clocks. A start bit is accepted only if the line is still low 8 ticks after the falling edge is seen. `char_bits` (7, 8 or 9) data bits follow, least significant first, each sampled 16 ticks after the previous sample, and then the stop bit is sampled.
- R2: When the stop bit is sampled and `buf_ready` is high, `rx_valid` pulses for one clock. In that clock `rx_data` holds the character in its low bits, with all higher bits zero, and receive-done (field 7, value 0x01) is set.
- R3: When the stop bit is sampled and `buf_ready` is low, the character is dropped with no `rx_valid`. Busy (field 5, value 0x04) is set in that same clock and in no earlier clock.
- R4: Delivery resumes with the next character once `buf_ready` is high again, with no software action.
- R5: A character with all data bits and the stop bit low is a break and is never delivered. Break-received (field 3, value 0x10) is set for the first such character only, and is not set again during the same unbroken low period.
- R6: After a break, break-end (field 1, value 0x40) is set once the line has been sampled high on 16 consecutive ticks. It is not set earlier. Characters that complete while a break is pending are not delivered. After break-end the receiver waits for a new start bit.
- R7: A one-clock `tx_done` pulse sets transmit-done (field 6, value 0x02).
- R8: Writing the event register (`reg_sel`=0) clears each bit written as 1 and leaves bits written as 0 unchanged. If hardware sets a bit in the same clock that a write clears it, the bit stays set.
- R9: Writing the mask register (`reg_sel`=1) stores only fields 1, 3, 5, 6 and 7 (mask 0x57). Fields 0, 2 and 4 read as zero in both registers.
- R10: `irq` is high exactly while some event bit and its mask bit are both set.
- R11: After reset both registers read zero, and `irq` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clocks per oversampling tick, minus one |
| char_bits | input | 4 | Number of data bits, 7 to 9 |
| rxd | input | 1 | Serial receive line, idle high |
| buf_ready | input | 1 | Downstream buffer free |
| rx_valid | output | 1 | One-clock strobe for a delivered character |
| rx_data | output | OUT_W | Delivered character, zero-extended |
| tx_done | input | 1 | One-clock pulse from the transmit path |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The line passes through two synchronising flops before the sampler sees it. As a result, a stop bit that the bench starts driving just after a falling clock edge is sampled at the 11th rising edge that follows. At that edge `rx_valid`, receive-done and busy all appear. The busy check reads the event register after the 10th and after the 11th edge, so it catches an event that arrives early as well as one that arrives late. Break-end is due at the 18th rising edge after the line returns high; the bench reads it after the 12th edge and again after the 19th. Register writes, `tx_done` and mask changes take effect at the next rising edge. Every read is therefore made one falling edge after the stimulus.

// File: rtl/uart_rx_evt.sv
module uart_rx_evt #(
  parameter int DIV_W    = 16,
  parameter int DATA_MAX = 9,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [3:0]       char_bits,
  input  logic             rxd,
  input  logic             buf_ready,
  output logic             rx_valid,
  output logic [OUT_W-1:0] rx_data,
  input  logic             tx_done,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  localparam int IDX_W = $clog2(DATA_MAX + 1);
  localparam int F_BRKE = 6;
  localparam int F_BRK  = 4;
  localparam int F_BSY  = 2;
  localparam int F_TXB  = 1;
  localparam int F_RXB  = 0;
  localparam logic [7:0] EV_USED = 8'h57;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t                 state;
  logic [1:0]          sync;
  logic                rxd_s;
  logic [DIV_W-1:0]    div_cnt;
  logic                tick;
  logic [3:0]          smp;
  logic [IDX_W-1:0]    bit_idx;
  logic [DATA_MAX-1:0] shreg;
  logic                in_break;
  logic [3:0]          hi_cnt;
  logic [7:0]          ev, mask, ev_set, ev_clr;
  logic                stop_evt, brk_char;
  logic                set_rxb, set_bsy, set_brk, set_brke;

  assign rxd_s    = sync[1];
  assign tick     = (div_cnt >= baud_div);
  assign stop_evt = tick && (state == S_STOP) && (smp == 4'd15);
  assign brk_char = (shreg == '0) && !rxd_s;
  assign set_brk  = stop_evt && brk_char && !in_break;
  assign set_rxb  = stop_evt && !brk_char && !in_break && buf_ready;
  assign set_bsy  = stop_evt && !brk_char && !in_break && !buf_ready;
  assign set_brke = tick && rxd_s && in_break && (hi_cnt == 4'd15);

  always_comb begin
    ev_set         = '0;
    ev_set[F_BRKE] = set_brke;
    ev_set[F_BRK]  = set_brk;
    ev_set[F_BSY]  = set_bsy;
    ev_set[F_TXB]  = tx_done;
    ev_set[F_RXB]  = set_rxb;
  end

  assign ev_clr    = (reg_wr && !reg_sel) ? reg_wdata : 8'h00;
  assign reg_rdata = reg_sel ? mask : ev;
  assign irq       = |(ev & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      div_cnt <= '0;
    end else begin
      sync    <= {sync[0], rxd};
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      smp      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      in_break <= 1'b0;
      hi_cnt   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE:
            if (!rxd_s) begin
              state <= S_START;
              smp   <= '0;
            end
          S_START:
            if (smp == 4'd7) begin
              if (!rxd_s) begin
                state   <= S_DATA;
                smp     <= '0;
                bit_idx <= '0;
                shreg   <= '0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              smp <= smp + 4'd1;
            end
          S_DATA: begin
            smp <= smp + 4'd1;
            if (smp == 4'd15) begin
              shreg[bit_idx] <= rxd_s;
              bit_idx        <= bit_idx + 1'b1;
              if (bit_idx == IDX_W'(char_bits - 4'd1)) state <= S_STOP;
            end
          end
          default: begin
            smp <= smp + 4'd1;
            if (smp == 4'd15) state <= S_IDLE;
          end
        endcase
        if (!rxd_s)                hi_cnt <= '0;
        else if (hi_cnt != 4'd15)  hi_cnt <= hi_cnt + 4'd1;
      end
      if (set_rxb) begin
        rx_valid <= 1'b1;
        rx_data  <= OUT_W'(shreg);
      end
      if (stop_evt && brk_char) in_break <= 1'b1;
      if (set_brke) begin
        in_break <= 1'b0;
        state    <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev   <= '0;
      mask <= '0;
    end else begin
      ev <= ((ev & ~ev_clr) | ev_set) & EV_USED;
      if (reg_wr && reg_sel) mask <= reg_wdata & EV_USED;
    end
  end
endmodule

module uart_rx_evt_chk #(
  parameter int DATA_MAX = 9,
  parameter int OUT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [OUT_W-1:0] rx_data,
  input logic             tx_done,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic [7:0]       ev,
  input logic [7:0]       mask
);
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R2
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> DATA_MAX) == '0));
  // R2
  rxb_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev[0]) |-> rx_valid);
  // R3
  bsy_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev[2]) |-> !rx_valid);
  // R7
  txb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> ev[1]);
  // R8
  w1c_txb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[1] && !tx_done) |=> !ev[1]);
  // R9
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (mask == ($past(reg_wdata) & 8'h57)));
  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 8'hA8) == 8'h00);
endmodule

bind uart_rx_evt uart_rx_evt_chk #(.DATA_MAX(DATA_MAX), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .tx_done(tx_done), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ev(ev), .mask(mask)
);

// File: tb/uart_rx_evt_tb.sv
module uart_rx_evt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = '0;
  logic [3:0]  char_bits = 4'd8;
  logic        rxd = 1'b1;
  logic        buf_ready = 1'b1;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        tx_done = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int got_n = 0;
  logic [15:0] got_d = '0;

  always #10 clk = ~clk;

  uart_rx_evt u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .char_bits(char_bits),
    .rxd(rxd), .buf_ready(buf_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_done(tx_done), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) if (rx_valid) begin
    got_n++;
    got_d = rx_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (16 * (int'(baud_div) + 1)) @(negedge clk);
  endtask

  task automatic frame(input logic [8:0] val, input int len);
    drive_bit(1'b0);
    for (int i = 0; i < len; i++) drive_bit(val[i]);
    drive_bit(1'b1);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk(v == 8'h00, "R11 event reg", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R11 mask reg", v, 0);
    chk(irq == 1'b0, "R11 irq", irq, 0);
    chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
  endtask

  task automatic t_char8;
    logic [7:0] v;
    int n0 = got_n;
    wr(1'b1, 8'h01);
    frame(9'h0A5, 8);
    chk(got_n == n0 + 1, "R2 one strobe", got_n - n0, 1);
    chk(got_d == 16'h00A5, "R1 data 8 bits", got_d, 16'h00A5);
    rd(1'b0, v); chk(v == 8'h01, "R2 receive-done", v, 8'h01);
    chk(irq == 1'b1, "R10 irq on unmasked event", irq, 1);
    wr(1'b0, 8'h01);
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);
  endtask

  task automatic t_char9;
    int n0 = got_n;
    char_bits = 4'd9;
    frame(9'h1C3, 9);
    chk(got_n == n0 + 1 && got_d == 16'h01C3, "R2 nine bits zero-extended", got_d, 16'h01C3);
    char_bits = 4'd8;
  endtask

  task automatic t_char7_div;
    int n0 = got_n;
    baud_div = 16'd2;
    char_bits = 4'd7;
    frame(9'h0D5, 7);
    chk(got_n == n0 + 1 && got_d == 16'h0055, "R1 seven bits, divided tick", got_d, 16'h0055);
    baud_div = '0;
    char_bits = 4'd8;
    repeat (4) @(negedge clk);
    wr(1'b0, 8'hFF);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    logic [7:0] dat = 8'h3C;
    int n0 = got_n;
    buf_ready = 1'b0;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(dat[i]);
    rxd = 1'b1;
    repeat (10) @(negedge clk);
    rd(1'b0, v); chk((v & 8'h04) == 0, "R3 busy not before stop mid", v, 0);
    @(negedge clk);
    rd(1'b0, v); chk((v & 8'h04) == 8'h04, "R3 busy at stop mid", v, 8'h04);
    repeat (13) @(negedge clk);
    chk(got_n == n0, "R3 char dropped", got_n - n0, 0);
  endtask

  task automatic t_resume;
    int n0 = got_n;
    buf_ready = 1'b1;
    frame(9'h096, 8);
    chk(got_n == n0 + 1 && got_d == 16'h0096, "R4 delivery resumes", got_d, 16'h0096);
    wr(1'b0, 8'hFF);
  endtask

  task automatic t_break;
    logic [7:0] v;
    int n0 = got_n;
    rxd = 1'b0;
    repeat (200) @(negedge clk);
    rd(1'b0, v); chk((v & 8'h50) == 8'h10, "R5 break-received set", v, 8'h10);
    wr(1'b0, 8'h10);
    repeat (400) @(negedge clk);
    rd(1'b0, v); chk(v == 8'h00, "R5 break event only once", v, 0);
    chk(got_n == n0, "R6 nothing delivered during break", got_n - n0, 0);
    rxd = 1'b1;
    repeat (12) @(negedge clk);
    rd(1'b0, v); chk((v & 8'h40) == 0, "R6 break-end not early", v, 0);
    repeat (7) @(negedge clk);
    rd(1'b0, v); chk((v & 8'h40) == 8'h40, "R6 break-end after idle bit", v, 8'h40);
    repeat (40) @(negedge clk);
    chk(got_n == n0, "R6 partial frame discarded", got_n - n0, 0);
    frame(9'h05A, 8);
    chk(got_n == n0 + 1 && got_d == 16'h005A, "R6 reception after break", got_d, 16'h005A);
    wr(1'b0, 8'hFF);
  endtask

  task automatic t_tx_w1c;
    logic [7:0] v;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    rd(1'b0, v); chk(v == 8'h02, "R7 transmit-done", v, 8'h02);
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk(v == 8'h02, "R8 write zero no effect", v, 8'h02);
    wr(1'b0, 8'hFD);
    rd(1'b0, v); chk(v == 8'h02, "R8 other ones leave bit", v, 8'h02);
    wr(1'b0, 8'h02);
    rd(1'b0, v); chk(v == 8'h00, "R8 write one clears", v, 0);
    tx_done = 1'b1;
    wr(1'b0, 8'h02);
    tx_done = 1'b0;
    rd(1'b0, v); chk(v == 8'h02, "R8 set wins over clear", v, 8'h02);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk(v == 8'h57, "R9 mask reserved zero", v, 8'h57);
    rd(1'b0, v); chk((v & 8'hA8) == 0, "R9 event reserved zero", v, 0);
    chk(irq == 1'b1, "R10 irq with mask all", irq, 1);
    wr(1'b1, 8'hFD);
    chk(irq == 1'b0, "R10 masked event no irq", irq, 0);
    wr(1'b1, 8'h02);
    chk(irq == 1'b1, "R10 irq re-enabled", irq, 1);
    wr(1'b0, 8'h02);
    chk(irq == 1'b0, "R10 irq after clear", irq, 0);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_char8();
    t_char9();
    t_char7_div();
    t_busy();
    t_resume();
    t_break();
    t_tx_w1c();
    t_mask();
    finish_sim();
  end
endmodule